// File: doc/BRIEF.md
# Register Write Coalescing Bridge

This bridge sits between a host register bus that writes in 16-bit or 32-bit units and a controller register file that must see the transfer-mode and command halfwords land together as one atomic 32-bit word. A halfword written to the transfer-mode offset is not forwarded. It is parked in a shadow register. A later halfword written to the command offset releases a single full-word write at the transfer-mode word address. That word places the command value in the upper half and the parked transfer-mode value in the lower half.

Other traffic is forwarded, with two adjustments. On a full-word write to the signal-enable register, the timeout-error and CRC-error enables are stripped. A full-word write to the interrupt-enable register is followed by a read-modify-write of the block-gap control byte. That read-modify-write mirrors the card-interrupt enable into bit 3 of the byte. Downstream requests use a valid/ready channel. The host side is stalled until every downstream operation started by the current request has completed.

Top module: `regbr_coalesce`

## Requirements
- R1: A halfword write (req_word_i=0) to offset 0x0C is captured into the shadow and produces no downstream request.
- R2: A halfword write to offset 0x0E produces exactly one downstream write. That write has dn_addr_o=0x0C, dn_be_o=4'b1111 and dn_wdata_o[31:16] equal to the written halfword.
- R3: The lower half of a merged word is the shadow value. The shadow is 0 after reset and keeps its value across any number of command writes until the next transfer-mode write.
- R4: A halfword write to any other offset is forwarded as one write to the word-aligned address. The value is taken from req_wdata_i[15:0], and upper bits are ignored. When address bit 1 is 0 the write has byte enables 4'b0011 and data {16'h0, value}. When address bit 1 is 1 it has byte enables 4'b1100 and data {value, 16'h0}.
- R5: A full-word write to offset 0x38 is forwarded with bits 16 (timeout) and 17 (CRC) cleared and all other bits unchanged. Full-word writes to other offsets are forwarded unchanged with byte enables 4'b1111.
- R6: A full-word write to offset 0x34 is forwarded unchanged. Once that write is accepted, a read of address 0x28 with byte enables 4'b0100 is issued. When the read data returns, a write to 0x28 with byte enables 4'b0100 follows. Its byte in bits [23:16] is the read byte with bit 3 replaced by bit 8 of the interrupt-enable value.
- R7: req_ready_o is low from the cycle after a forwarding request is accepted until its last downstream operation completes. req_ready_o is high out of reset.
- R8: While dn_valid_o is high and dn_ready_i is low, the downstream address, data, byte enables and write flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host write request valid |
| req_ready_o | output | 1 | Bridge can accept a host write |
| req_word_i | input | 1 | 1 = 32-bit write, 0 = 16-bit write |
| req_addr_i | input | AW | Host byte address |
| req_wdata_i | input | 32 | Host write data (halfword in bits 15:0) |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request accepted |
| dn_we_o | output | 1 | 1 = write, 0 = read |
| dn_addr_o | output | AW | Downstream word-aligned address |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_be_o | output | 4 | Downstream byte enables |
| dn_rvalid_i | input | 1 | Read data valid |
| dn_rdata_i | input | 32 | Read data |

## Verification
The merge is exercised in three situations. A command write is issued straight out of reset to show the zero shadow. A command write follows a transfer-mode write whose upper data bits are junk, which shows that only the halfword is kept. Back-to-back command writes show the shadow is retained and not consumed. Halfword pass-through is tried at both lane positions to separate the byte-enable and placement choices. Signal-enable writes are compared with a neighbouring full-word write to show that the masking is tied to the offset. Interrupt-enable writes with the card bit set and with it clear show the bit being mirrored and the rest of the gap byte preserved. Repeating both flows under a throttled ready shows the host stall and the exactly-once delivery.

// File: rtl/regbr_pkg.sv
package regbr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned HW = DW / 2;
  localparam int unsigned BW = DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_RWAIT,
    ST_GWR
  } seq_st_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [BW-1:0] be;
    logic          rmw;
    logic          set;
  } wr_op_t;
endpackage

// File: rtl/regbr_shadow.sv
module regbr_shadow #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_o <= '0;
    else if (load_i) shadow_o <= din_i;
  end
endmodule

// File: rtl/regbr_decode.sv
module regbr_decode import regbr_pkg::*; #(
  parameter int unsigned   AW         = 8,
  parameter logic [AW-1:0] XFER_OFS   = 8'h0C,
  parameter logic [AW-1:0] CMD_OFS    = 8'h0E,
  parameter logic [AW-1:0] SIGEN_OFS  = 8'h38,
  parameter logic [AW-1:0] INTEN_OFS  = 8'h34,
  parameter logic [DW-1:0] SIG_CLR    = 32'h0003_0000,
  parameter logic [DW-1:0] CARD_INT   = 32'h0000_0100
) (
  input  logic          word_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [HW-1:0] shadow_i,
  output logic          capture_o,
  output logic          is_cmd_o,
  output logic [AW-1:0] addr_o,
  output wr_op_t        op_o
);
  localparam logic [AW-1:0] XFER_WORD = {XFER_OFS[AW-1:2], 2'b00};

  logic [HW-1:0] half;
  assign half = wdata_i[HW-1:0];

  always_comb begin
    capture_o = !word_i && (addr_i == XFER_OFS);
    is_cmd_o  = !word_i && (addr_i == CMD_OFS);
    addr_o    = {addr_i[AW-1:2], 2'b00};
    op_o.rmw  = 1'b0;
    op_o.set  = |(wdata_i & CARD_INT);
    op_o.be   = '1;
    op_o.data = wdata_i;
    if (word_i) begin
      if (addr_i == SIGEN_OFS) op_o.data = wdata_i & ~SIG_CLR;
      if (addr_i == INTEN_OFS) op_o.rmw  = 1'b1;
    end else if (is_cmd_o) begin
      // command rides the upper half of the transfer-mode word
      addr_o    = XFER_WORD;
      op_o.data = {half, shadow_i};
    end else if (addr_i[1]) begin
      op_o.data = {half, {HW{1'b0}}};
      op_o.be   = {{(BW/2){1'b1}}, {(BW/2){1'b0}}};
    end else begin
      op_o.data = {{HW{1'b0}}, half};
      op_o.be   = {{(BW/2){1'b0}}, {(BW/2){1'b1}}};
    end
  end
endmodule

// File: rtl/regbr_seq.sv
module regbr_seq import regbr_pkg::*; #(
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] GAP_OFS = 8'h2A,
  parameter int unsigned   GAP_BIT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [AW-1:0] addr_i,
  input  wr_op_t        op_i,
  output logic          idle_o,
  output logic          dn_valid_o,
  input  logic          dn_ready_i,
  output logic          dn_we_o,
  output logic [AW-1:0] dn_addr_o,
  output logic [DW-1:0] dn_wdata_o,
  output logic [BW-1:0] dn_be_o,
  input  logic          dn_rvalid_i,
  input  logic [DW-1:0] dn_rdata_i
);
  localparam int unsigned   GAP_LANE = int'(GAP_OFS[1:0]);
  localparam logic [AW-1:0] GAP_WORD = {GAP_OFS[AW-1:2], 2'b00};
  localparam logic [BW-1:0] GAP_BE   = BW'(1) << GAP_LANE;
  localparam logic [2:0]    GBIT     = GAP_BIT[2:0];

  seq_st_e       st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [BW-1:0] be_q;
  logic          we_q, rmw_q, set_q;
  logic [7:0]    gap_byte;
  logic          unused_rdata;

  assign unused_rdata = ^dn_rdata_i;

  always_comb begin
    gap_byte       = dn_rdata_i[8*GAP_LANE +: 8];
    gap_byte[GBIT] = set_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
      we_q   <= 1'b0;
      rmw_q  <= 1'b0;
      set_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (launch_i) begin
          addr_q <= addr_i;
          data_q <= op_i.data;
          be_q   <= op_i.be;
          we_q   <= 1'b1;
          rmw_q  <= op_i.rmw;
          set_q  <= op_i.set;
          st_q   <= ST_WR;
        end
        ST_WR: if (dn_ready_i) begin
          if (rmw_q) begin
            addr_q <= GAP_WORD;
            be_q   <= GAP_BE;
            data_q <= '0;
            we_q   <= 1'b0;
            st_q   <= ST_RD;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_RD:    if (dn_ready_i) st_q <= ST_RWAIT;
        ST_RWAIT: if (dn_rvalid_i) begin
          data_q <= DW'(gap_byte) << (8 * GAP_LANE);
          we_q   <= 1'b1;
          st_q   <= ST_GWR;
        end
        ST_GWR:   if (dn_ready_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == ST_IDLE);
  assign dn_valid_o = (st_q == ST_WR) || (st_q == ST_RD) || (st_q == ST_GWR);
  assign dn_we_o    = we_q;
  assign dn_addr_o  = addr_q;
  assign dn_wdata_o = data_q;
  assign dn_be_o    = be_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ready_i |=> dn_valid_o && $stable(dn_addr_o) && $stable(dn_wdata_o)
      && $stable(dn_be_o) && $stable(dn_we_o)); // R8
  AST_GAP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR) && rmw_q && dn_ready_i |=> dn_valid_o && !dn_we_o
      && dn_addr_o == GAP_WORD && dn_be_o == GAP_BE); // R6
  AST_GAP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RWAIT) && dn_rvalid_i |=> dn_valid_o && dn_we_o && dn_be_o == GAP_BE
      && dn_wdata_o[8*GAP_LANE+GAP_BIT] == $past(set_q)); // R6
endmodule

// File: rtl/regbr_coalesce.sv
module regbr_coalesce import regbr_pkg::*; #(
  parameter int unsigned   AW        = 8,
  parameter logic [AW-1:0] XFER_OFS  = 8'h0C,
  parameter logic [AW-1:0] CMD_OFS   = 8'h0E,
  parameter logic [AW-1:0] SIGEN_OFS = 8'h38,
  parameter logic [AW-1:0] INTEN_OFS = 8'h34,
  parameter logic [AW-1:0] GAP_OFS   = 8'h2A,
  parameter int unsigned   GAP_BIT   = 3,
  parameter logic [31:0]   SIG_CLR   = 32'h0003_0000,
  parameter logic [31:0]   CARD_INT  = 32'h0000_0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_word_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          dn_valid_o,
  input  logic          dn_ready_i,
  output logic          dn_we_o,
  output logic [AW-1:0] dn_addr_o,
  output logic [31:0]   dn_wdata_o,
  output logic [3:0]    dn_be_o,
  input  logic          dn_rvalid_i,
  input  logic [31:0]   dn_rdata_i
);
  localparam logic [AW-1:0] XFER_WORD = {XFER_OFS[AW-1:2], 2'b00};

  logic          idle, accept, capture, is_cmd;
  logic [HW-1:0] shadow;
  logic [AW-1:0] fwd_addr;
  wr_op_t        fwd_op;

  assign req_ready_o = idle;
  assign accept      = req_valid_i && idle;

  regbr_shadow #(.W(HW)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept && capture),
    .din_i    (req_wdata_i[HW-1:0]),
    .shadow_o (shadow)
  );

  regbr_decode #(
    .AW(AW), .XFER_OFS(XFER_OFS), .CMD_OFS(CMD_OFS), .SIGEN_OFS(SIGEN_OFS),
    .INTEN_OFS(INTEN_OFS), .SIG_CLR(SIG_CLR), .CARD_INT(CARD_INT)
  ) u_decode (
    .word_i    (req_word_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .shadow_i  (shadow),
    .capture_o (capture),
    .is_cmd_o  (is_cmd),
    .addr_o    (fwd_addr),
    .op_o      (fwd_op)
  );

  regbr_seq #(.AW(AW), .GAP_OFS(GAP_OFS), .GAP_BIT(GAP_BIT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (accept && !capture),
    .addr_i      (fwd_addr),
    .op_i        (fwd_op),
    .idle_o      (idle),
    .dn_valid_o  (dn_valid_o),
    .dn_ready_i  (dn_ready_i),
    .dn_we_o     (dn_we_o),
    .dn_addr_o   (dn_addr_o),
    .dn_wdata_o  (dn_wdata_o),
    .dn_be_o     (dn_be_o),
    .dn_rvalid_i (dn_rvalid_i),
    .dn_rdata_i  (dn_rdata_i)
  );

  AST_XFER_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !req_word_i && req_addr_i == XFER_OFS |=> !dn_valid_o && req_ready_o); // R1
  AST_MERGE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_cmd |=> dn_valid_o && dn_we_o && dn_be_o == 4'hF && dn_addr_o == XFER_WORD
      && dn_wdata_o[31:16] == $past(req_wdata_i[15:0])); // R2
  AST_MERGE_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_cmd |=> dn_wdata_o[15:0] == $past(shadow)); // R3
  AST_SIG_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && req_word_i && req_addr_i == SIGEN_OFS |=> (dn_wdata_o & SIG_CLR) == '0); // R5
  AST_STALL_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> !req_ready_o); // R7
endmodule

// File: tb/tb_regbr_coalesce.sv
`timescale 1ns/1ps
module tb_regbr_coalesce;
  typedef struct packed {
    logic        word;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [1:0]  n;
    logic [7:0]  eaddr;
    logic [31:0] edata;
    logic [3:0]  ebe;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h0E, 32'hAAAA_1234, 2'd1, 8'h0C, 32'h1234_0000, 4'hF, 4'd3}, // R3 zero shadow
    '{1'b0, 8'h0C, 32'hFFFF_0037, 2'd0, 8'h00, 32'h0,         4'h0, 4'd1}, // R1
    '{1'b0, 8'h0E, 32'h0000_0C1A, 2'd1, 8'h0C, 32'h0C1A_0037, 4'hF, 4'd2}, // R2
    '{1'b0, 8'h0E, 32'h5555_0D3B, 2'd1, 8'h0C, 32'h0D3B_0037, 4'hF, 4'd3}, // R3 retained
    '{1'b0, 8'h04, 32'h1111_BEEF, 2'd1, 8'h04, 32'h0000_BEEF, 4'h3, 4'd4}, // R4 low lane
    '{1'b0, 8'h06, 32'h0000_5A5A, 2'd1, 8'h04, 32'h5A5A_0000, 4'hC, 4'd4}, // R4 high lane
    '{1'b1, 8'h38, 32'hFFFF_FFFF, 2'd1, 8'h38, 32'hFFFC_FFFF, 4'hF, 4'd5}, // R5 masked
    '{1'b1, 8'h3C, 32'hFFFF_FFFF, 2'd1, 8'h3C, 32'hFFFF_FFFF, 4'hF, 4'd5}, // R5 other offset
    '{1'b1, 8'h38, 32'h0003_0001, 2'd1, 8'h38, 32'h0000_0001, 4'hF, 4'd5}  // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_word = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic dn_ready = 1'b1, dn_rvalid = 1'b0;
  logic [31:0] dn_rdata = '0;
  logic req_ready, dn_valid, dn_we;
  logic [7:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [3:0] dn_be;

  int n_chk = 0, n_bad = 0, cyc = 0, rec_n = 0;
  logic stall_mode = 1'b0, rd_pend = 1'b0;
  logic [7:0] gap_mem = 8'hA5;
  logic [7:0]  r_addr [64];
  logic [31:0] r_data [64];
  logic [3:0]  r_be   [64];
  logic        r_we   [64];

  always #5 clk = ~clk;

  regbr_coalesce dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_word_i(req_word), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_we_o(dn_we), .dn_addr_o(dn_addr),
    .dn_wdata_o(dn_wdata), .dn_be_o(dn_be), .dn_rvalid_i(dn_rvalid), .dn_rdata_i(dn_rdata)
  );

  // downstream responder and recorder
  always @(negedge clk) begin
    cyc++;
    dn_rvalid = 1'b0;
    if (rd_pend) begin
      dn_rvalid = 1'b1;
      dn_rdata  = 32'hDE00_BEEF | ({24'h0, gap_mem} << 16);
      rd_pend   = 1'b0;
    end
    dn_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
    if (dn_valid && dn_ready) begin
      r_addr[rec_n % 64] = dn_addr;
      r_data[rec_n % 64] = dn_wdata;
      r_be[rec_n % 64]   = dn_be;
      r_we[rec_n % 64]   = dn_we;
      rec_n++;
      if (!dn_we) rd_pend = 1'b1;
      else if (dn_addr == 8'h28 && dn_be == 4'b0100) gap_mem = dn_wdata[23:16];
    end
  end

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_word = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready || dn_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_rec(input int idx, input string rq, input logic [7:0] a,
                           input logic [31:0] d, input logic [3:0] be, input logic we);
    check(r_addr[idx] == a && r_data[idx] == d && r_be[idx] == be && r_we[idx] == we, rq,
          {r_we[idx], r_be[idx], r_addr[idx], r_data[idx]}, {we, be, a, d});
  endtask

  task automatic gap_flow(input logic [31:0] v, input logic [7:0] exp_byte, input string rq);
    int base;
    base = rec_n;
    do_req(1'b1, 8'h34, v);
    wait_idle();
    check(rec_n - base == 3, rq, 64'(rec_n - base), 64'd3);
    check_rec(base, rq, 8'h34, v, 4'hF, 1'b1);
    check_rec(base + 1, rq, 8'h28, 32'h0, 4'b0100, 1'b0);
    check_rec(base + 2, rq, 8'h28, {8'h0, exp_byte, 16'h0}, 4'b0100, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(req_ready == 1'b1, "R7 reset ready", 64'(req_ready), 64'd1);
    check(dn_valid == 1'b0, "R7 reset dn_valid", 64'(dn_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      base = rec_n;
      do_req(VECS[i].word, VECS[i].addr, VECS[i].data);
      wait_idle();
      if (VECS[i].n == 2'd0)
        check(rec_n == base, $sformatf("R%0d vec%0d", VECS[i].rq, i), 64'(rec_n - base), 64'd0);
      else
        check(rec_n - base == 1 && r_addr[base] == VECS[i].eaddr && r_data[base] == VECS[i].edata
              && r_be[base] == VECS[i].ebe && r_we[base],
              $sformatf("R%0d vec%0d", VECS[i].rq, i),
              {r_be[base], r_addr[base], r_data[base]}, {VECS[i].ebe, VECS[i].eaddr, VECS[i].edata});
    end

    // R6: card-interrupt bit set, then clear; other gap bits preserved
    gap_flow(32'h1234_01FF, 8'hAD, "R6 set");
    check(gap_mem == 8'hAD, "R6 gap byte", 64'(gap_mem), 64'hAD);
    gap_flow(32'hFFFF_FEFF, 8'hA5, "R6 clear");

    // R7, R8: throttled downstream
    stall_mode = 1'b1;
    base = rec_n;
    do_req(1'b0, 8'h0E, 32'h0000_0777);
    check(req_ready == 1'b0 && dn_valid == 1'b1, "R7 stall", {req_ready, dn_valid}, 64'b01);
    wait_idle();
    check(rec_n - base == 1, "R8 once", 64'(rec_n - base), 64'd1);
    check_rec(base, "R8 merged", 8'h0C, 32'h0777_0037, 4'hF, 1'b1);
    gap_flow(32'h0000_0100, 8'hAD, "R8 gap stalled");
    stall_mode = 1'b0;

    // R1: a new capture changes later merges
    do_req(1'b0, 8'h0C, 32'h0000_4242);
    base = rec_n;
    do_req(1'b0, 8'h0E, 32'h0000_0001);
    wait_idle();
    check(rec_n - base == 1 && r_data[base] == 32'h0001_4242, "R1 recapture",
          64'(r_data[base]), 64'h0001_4242);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule